// File: doc/BRIEF.md
# PWM Compare Buffer Transfer Gate

This block manages the two-stage refresh of a compare value in a complementary PWM timer. Software writes a new value into a buffer register. From there it moves to a temporary register, and on a chosen turning point of the triangle counter it moves on to the compare register that the waveform logic uses. The second stage always runs on its own schedule. The first stage can run freely, be held off entirely, or be allowed only inside windows produced by an interrupt-skipping counter.

Two skip counters, one for crest events and one for trough events, each count their strobes against a 3-bit limit. Each counter produces a strobe on every (limit+1)th event: this is the interrupt that skipping lets through. The block's outputs are that strobe pair, the temporary register and the compare register. A buffer write leaves a pending value behind. The pending value moves to the temporary register on the first clock where the current mode permits a move.

The reset is asynchronous and active low. It is expected to be released synchronously to `clk` upstream.

Top module: `pwm_xfer_gate`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the temporary and compare outputs read zero. The skip counters and the pending flag are clear.
- R2: With mode field 2'b00 (normal), or the reserved code 2'b11 that acts the same, a pending buffer value is copied into the temporary register on the next rising clock.
- R3: With mode field 2'b01 (hold), the temporary register never changes, even if buffer writes arrive.
- R4: On a rising clock where the selected strobe is high, the compare register loads the temporary register's value from before that clock. The crest strobe is selected when the select input is 0 and the trough strobe when it is 1. This happens in every mode.
- R5: With its skip enable high and limit N, a skip counter asserts its strobe, in the same cycle, on every (N+1)th event of its source, and it then wraps to zero. A limit of 0 passes every event. With its enable low the counter holds at zero and its strobe follows every event.
- R6: With mode field 2'b10 (linked), moves are permitted only while an enabled source with a nonzero limit has its counter equal to its limit. That window runs from the clock after the event that brings the counter to N, through the cycle of that source's next event. When both sources qualify, the permitted period is the union of their windows.
- R7: With mode field 2'b10 while both sources are disabled or both have a limit of 0, the temporary register never loads.
- R8: A buffer write sets the pending flag. A move clears the flag unless a write arrives in the same cycle. In that case the move takes the older value and the newly written value stays pending.
- R9: A value written while moves are blocked is moved to the temporary register on the first permitted clock after the block leaves hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crest_i | input | 1 | Triangle counter crest strobe |
| trough_i | input | 1 | Triangle counter trough strobe |
| crest_skip_en_i | input | 1 | Enables skipping of crest events |
| trough_skip_en_i | input | 1 | Enables skipping of trough events |
| crest_skip_cnt_i | input | SKIP_W | Crest skip limit N |
| trough_skip_cnt_i | input | SKIP_W | Trough skip limit N |
| xfer_mode_i | input | 2 | Buffer-to-temporary mode: 00 normal, 01 hold, 10 linked, 11 as 00 |
| cmp_sel_trough_i | input | 1 | Compare load point: 0 crest, 1 trough |
| buf_wr_i | input | 1 | Buffer write strobe |
| buf_data_i | input | DATA_W | Buffer write data |
| tmp_o | output | DATA_W | Temporary register |
| cmp_o | output | DATA_W | Compare register |
| crest_irq_o | output | 1 | Crest interrupt after skipping |
| trough_irq_o | output | 1 | Trough interrupt after skipping |

## Verification
The bench builds the block with DATA_W = 12 and SKIP_W = 3. With these widths every skip limit from 0 to 7 can be reached, including the top value, where the window falls in the last of eight events. The crest and trough strobes come from a modelled triangle period of eight cycles, so the bench covers crest-only, trough-only and overlapping windows, and the switch between crest and trough load points, within a few thousand cycles. Random buffer writes land on window edges, on load points and in the same cycle as moves.

// File: rtl/pwm_xfer_pkg.sv
package pwm_xfer_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_HOLD   = 2'b01,
    XM_LINKED = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_CREST  = 0;
  localparam int unsigned SRC_TROUGH = 1;
endpackage

// File: rtl/pwm_skip_counter.sv
module pwm_skip_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             irq_o,
  output logic             win_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;
  logic             cnt_ce;

  always_comb begin
    wrap   = (cnt_q >= limit_i);
    cnt_ce = !en_i || event_i;
    cnt_d  = cnt_q;
    if (!en_i)        cnt_d = '0;
    else if (event_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    irq_o  = event_i && (!en_i || wrap);
    win_o  = en_i && (limit_i != '0) && (cnt_q == limit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R5: a strobe only ever appears on an event
  a_r5_irq_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> event_i);
  // R5: a disabled counter sits at zero
  a_r5_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  // R5: without an event, an enabled counter does not move
  a_r5_hold_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !event_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_xfer_permit.sv
module pwm_xfer_permit
  import pwm_xfer_pkg::*;
(
  input  logic [1:0]         mode_i,
  input  logic [NUM_SRC-1:0] win_i,
  output logic               permit_o
);
  always_comb begin
    unique case (xfer_mode_e'(mode_i))
      XM_HOLD:   permit_o = 1'b0;
      XM_LINKED: permit_o = |win_i;
      default:   permit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwm_xfer_gate.sv
module pwm_xfer_gate
  import pwm_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crest_i,
  input  logic              trough_i,
  input  logic              crest_skip_en_i,
  input  logic              trough_skip_en_i,
  input  logic [SKIP_W-1:0] crest_skip_cnt_i,
  input  logic [SKIP_W-1:0] trough_skip_cnt_i,
  input  logic [1:0]        xfer_mode_i,
  input  logic              cmp_sel_trough_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic [DATA_W-1:0] tmp_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              crest_irq_o,
  output logic              trough_irq_o
);
  logic [NUM_SRC-1:0]   src_ev, src_en, src_irq, src_win;
  logic [SKIP_W-1:0]    src_lim [NUM_SRC];

  assign src_ev[SRC_CREST]   = crest_i;
  assign src_ev[SRC_TROUGH]  = trough_i;
  assign src_en[SRC_CREST]   = crest_skip_en_i;
  assign src_en[SRC_TROUGH]  = trough_skip_en_i;
  assign src_lim[SRC_CREST]  = crest_skip_cnt_i;
  assign src_lim[SRC_TROUGH] = trough_skip_cnt_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_skip
    pwm_skip_counter #(.CNT_W(SKIP_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (src_ev[s]),
      .en_i    (src_en[s]),
      .limit_i (src_lim[s]),
      .irq_o   (src_irq[s]),
      .win_o   (src_win[s])
    );
  end

  assign crest_irq_o  = src_irq[SRC_CREST];
  assign trough_irq_o = src_irq[SRC_TROUGH];

  logic permit;
  pwm_xfer_permit u_permit (
    .mode_i   (xfer_mode_i),
    .win_i    (src_win),
    .permit_o (permit)
  );

  logic [DATA_W-1:0] buf_q, tmp_q, cmp_q, buf_d, tmp_d, cmp_d;
  logic              pend_q, pend_d;
  logic              move, load;

  always_comb begin
    move   = pend_q && permit;
    load   = cmp_sel_trough_i ? trough_i : crest_i;
    buf_d  = buf_data_i;
    tmp_d  = buf_q;
    cmp_d  = tmp_q;
    pend_d = buf_wr_i || (pend_q && !move);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        buf_q <= '0;
    else if (buf_wr_i) buf_q <= buf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmp_q <= '0;
    else if (move) tmp_q <= tmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= '0;
    else if (load) cmp_q <= cmp_d;
  end

  assign tmp_o = tmp_q;
  assign cmp_o = cmp_q;

  // R3: hold mode freezes the temporary register
  a_r3_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_mode_i == 2'b01) |=> $stable(tmp_o));
  // R4: compare changes only at the selected load point
  a_r4_cmp_only_at_point: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_sel_trough_i ? trough_i : crest_i) |=> $stable(cmp_o));
  // R7: linked mode with skipping off never loads
  a_r7_linked_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((xfer_mode_i == 2'b10) &&
     ((!crest_skip_en_i && !trough_skip_en_i) ||
      (crest_skip_cnt_i == '0 && trough_skip_cnt_i == '0))) |=> $stable(tmp_o));
  // R8: a write always leaves a value pending
  a_r8_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_i |=> pend_q);
  // R2: in normal mode a pending value without a new write is consumed
  a_r2_normal_drains: assert property (@(posedge clk) disable iff (!rst_n)
    ((xfer_mode_i == 2'b00 || xfer_mode_i == 2'b11) && pend_q && !buf_wr_i) |=> !pend_q);
endmodule

// File: tb/pwm_xfer_gate_test.sv
module pwm_xfer_gate_test;
  localparam int DW = 12;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          crest, trough, c_en, t_en, sel, wr;
  logic [SW-1:0] c_n, t_n;
  logic [1:0]    mode;
  logic [DW-1:0] wdata, tmp_o, cmp_o;
  logic          c_irq, t_irq;

  pwm_xfer_gate #(.DATA_W(DW), .SKIP_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .crest_i(crest), .trough_i(trough),
    .crest_skip_en_i(c_en), .trough_skip_en_i(t_en),
    .crest_skip_cnt_i(c_n), .trough_skip_cnt_i(t_n),
    .xfer_mode_i(mode), .cmp_sel_trough_i(sel),
    .buf_wr_i(wr), .buf_data_i(wdata),
    .tmp_o(tmp_o), .cmp_o(cmp_o), .crest_irq_o(c_irq), .trough_irq_o(t_irq)
  );

  int checks = 0, errors = 0;
  int k = 0;
  int m_cnt [2];
  int m_buf, m_pend, m_tmp, m_cmp;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit src_ev(int s);
    return (s == 0) ? crest : trough;
  endfunction
  function automatic bit src_en(int s);
    return (s == 0) ? c_en : t_en;
  endfunction
  function automatic int src_n(int s);
    return (s == 0) ? int'(c_n) : int'(t_n);
  endfunction

  function automatic string tmp_tag();
    bit off;
    off = (!c_en && !t_en) || (c_n == 0 && t_n == 0);
    if (mode == 2'b01) return "R3 tmp";
    if (mode == 2'b10) return off ? "R7 tmp" : "R6 tmp";
    return "R2/R8 tmp";
  endfunction

  // One cycle: drive after a falling edge, compare, advance the model, wait.
  task automatic cycle(input bit w, input int d);
    bit permit, move, ld;
    bit win [2];
    crest  = (k % 8 == 0);
    trough = (k % 8 == 4);
    k++;
    wr = w; wdata = DW'(d);
    #1;
    check(tmp_tag(), int'(tmp_o), m_tmp);
    check("R4 cmp", int'(cmp_o), m_cmp);
    for (int s = 0; s < 2; s++) begin
      bit exp_irq;
      exp_irq = src_ev(s) && (!src_en(s) || m_cnt[s] >= src_n(s));
      check((s == 0) ? "R5 crest irq" : "R5 trough irq",
            (s == 0) ? int'(c_irq) : int'(t_irq), int'(exp_irq));
      win[s] = src_en(s) && src_n(s) != 0 && m_cnt[s] == src_n(s);
    end
    case (mode)
      2'b01:   permit = 1'b0;
      2'b10:   permit = win[0] || win[1];
      default: permit = 1'b1;
    endcase
    move = (m_pend != 0) && permit;
    ld   = sel ? trough : crest;
    if (ld)   m_cmp = m_tmp;
    if (move) m_tmp = m_buf;
    m_pend = (w || (m_pend != 0 && !move)) ? 1 : 0;
    if (w) m_buf = d;
    for (int s = 0; s < 2; s++) begin
      if (!src_en(s)) m_cnt[s] = 0;
      else if (src_ev(s)) m_cnt[s] = (m_cnt[s] >= src_n(s)) ? 0 : m_cnt[s] + 1;
    end
    @(negedge clk);
  endtask

  task automatic run(int n, int wr_pct);
    for (int i = 0; i < n; i++) begin
      bit w;
      w = ($urandom_range(99) < wr_pct);
      cycle(w, int'($urandom_range((1 << DW) - 1)));
    end
  endtask

  task automatic setup(bit ce, int cn, bit te, int tn, int md, bit sl);
    c_en = ce; c_n = SW'(cn); t_en = te; t_n = SW'(tn);
    mode = 2'(md); sel = sl;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hold_tmp;
    rst_n = 1'b0; crest = 0; trough = 0; wr = 0; wdata = '0;
    setup(0, 0, 0, 0, 0, 0);
    m_cnt[0] = 0; m_cnt[1] = 0; m_buf = 0; m_pend = 0; m_tmp = 0; m_cmp = 0;
    repeat (3) @(negedge clk);
    check("R1 tmp in reset", int'(tmp_o), 0);
    check("R1 cmp in reset", int'(cmp_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tmp after release", int'(tmp_o), 0);
    check("R1 cmp after release", int'(cmp_o), 0);

    // R8: back-to-back writes in normal mode
    cycle(1, 'h111);
    cycle(1, 'h222);
    check("R8 older value moved", int'(tmp_o), 'h111);
    cycle(0, 0);
    check("R8 newer value moved", int'(tmp_o), 'h222);

    // R3 then R9: write while held, release to normal
    setup(0, 0, 0, 0, 1, 0);
    cycle(1, 'h5A5);
    cycle(0, 0);
    cycle(0, 0);
    check("R3 held value", int'(tmp_o), 'h222);
    setup(0, 0, 0, 0, 0, 0);
    cycle(0, 0);
    check("R9 released value", int'(tmp_o), 'h5A5);

    // Random phases across modes, sources and load points
    setup(0, 0, 0, 0, 0, 0); run(300, 20);   // R2
    setup(1, 2, 0, 0, 3, 1); run(300, 20);   // R2 reserved code, R4 trough point
    setup(1, 3, 1, 1, 1, 0); run(300, 30);   // R3 hold, skips running
    setup(0, 0, 0, 0, 0, 0); run(50, 0);     // R9 drain
    setup(1, 1, 0, 0, 2, 0); run(400, 15);   // R6 crest only
    setup(0, 0, 1, 2, 2, 1); run(400, 15);   // R6 trough only
    setup(1, 3, 1, 5, 2, 0); run(600, 15);   // R6 union
    setup(1, 7, 1, 7, 2, 1); run(800, 10);   // R6 top limit
    setup(1, 0, 1, 0, 2, 0); run(300, 25);   // R7 limits zero, R5 pass-through
    hold_tmp = int'(tmp_o);
    setup(0, 4, 0, 6, 2, 1); run(300, 25);   // R7 enables off
    check("R7 tmp unchanged", int'(tmp_o), hold_tmp);
    setup(1, 4, 1, 6, 2, 1); run(500, 10);   // R9 linked resumes
    setup(1, 5, 0, 3, 0, 0); run(300, 30);   // R5 mixed enables

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule